// File: doc/BRIEF.md
# Interrupt Source State Register Bank

This block keeps four pieces of state for every interrupt source: an enable bit, a pending bit, an active flag and an 8-bit priority byte. Software reaches the state through a synchronous word-addressed bus with 32-bit data and byte strobes. Hardware reaches it through per-source request pulses, an acknowledge strobe and a completion strobe. The request pulses raise pending. The acknowledge moves one source from pending to active. The completion drops active again.

Enable and pending each appear at two addresses. One address sets bits and the other clears them, so software can change a single source without a read-modify-write. Reading either address returns the live state. Source n sits in word n/32 of an array, at bit n mod 32. The priority bytes are packed four to a word, with the lowest source in the lowest byte. A trigger word lets software raise pending on a source by writing its number.

The state vectors are also brought out on output pins for the logic that arbitrates between sources. The bus has no handshake and no back-pressure. A write takes effect at the clock edge where `bus_wr` is sampled high. A read always returns its data exactly one cycle later, marked by `bus_rvalid`. Arbitration and bus error responses are not part of this block.

Top module: `irq_state_bank`

## Requirements
- R1: A write to the enable-set alias (word addresses 0x000–0x007, byte offsets 0x000–0x01C) sets each enable bit whose data bit is 1. Data bits of 0 leave the matching enable bit unchanged. Enable never changes in a cycle without a bus write.
- R2: A write to the enable-clear alias (word addresses 0x020–0x027) clears each enable bit whose data bit is 1. Data bits of 0 leave the matching enable bit unchanged.
- R3: A read of word w of either alias of an array returns the current state of sources 32w to 32w+31, with source n at bit n mod 32. The arrays are: enable at 0x000/0x020, pending at 0x040/0x060, and active at 0x080. Any unmapped word address reads as zero.
- R4: Writes to the pending-set alias (word addresses 0x040–0x047) set pending bits whose data bit is 1. Writes to the pending-clear alias (word addresses 0x060–0x067) clear pending bits whose data bit is 1. Data bits of 0 have no effect.
- R5: A cycle with `irq_req[n]` high makes pending[n] 1 on the following cycle. This holds even when the same cycle carries a software pending-clear for source n.
- R6: An acknowledge for source n (`ack_valid` with `ack_id`=n) clears pending[n] and sets active[n] at the same edge, unless a request for n arrives in that cycle, in which case pending stays 1. A completion for n (`done_valid` with `done_id`=n) clears active[n]. If an acknowledge and a completion name the same source in one cycle, active ends up 1.
- R7: The active array (word addresses 0x080–0x087) is read-only. Bus writes there leave every active bit unchanged.
- R8: Priority bytes start at word address 0x0C0. Byte k of word 0x0C0+w holds the priority of source 4w+k, and only bytes whose strobe is 1 are written.
- R9: Sources at or above NUM_SRC (default 60) do not exist. Their bits read as zero and ignore writes: bits 28–31 of word 1, words 2–7 of each array, priority bytes past source 59, and out-of-range acknowledge, completion or trigger numbers.
- R10: A write to the trigger word (word address 0x380, byte offset 0xE00) with strobe bit 0 set raises pending on the source numbered by data bits 7:0.
- R11: After reset, every state bit and every priority byte is zero. Each read returns its data on `bus_rdata` with `bus_rvalid` high exactly one cycle after `bus_rd`, and `bus_rvalid` is low otherwise. The returned data is the state from before any write at that same edge.
- R12: For the set and clear aliases, data bit b takes effect only when strobe bit b/8 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_addr | input | 10 | Word address (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes for the write |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_req | input | NUM_SRC | Per-source request pulses |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 8 | Source being acknowledged |
| done_valid | input | 1 | Completion strobe |
| done_id | input | 8 | Source whose handler completed |
| enable_o | output | NUM_SRC | Enable state per source |
| pending_o | output | NUM_SRC | Pending state per source |
| active_o | output | NUM_SRC | Active state per source |
| prio_o | output | 8*NUM_SRC | Priority bytes, source n at bits 8n+7:8n |

## Verification
Every state change made by a bus write, request, acknowledge or completion appears on the state outputs one cycle after the edge that samples the stimulus. A read returns its data one cycle after `bus_rd`, holding the state from before that edge. The bench drives inputs on the falling edge and lets one rising edge pass. It computes the expected read word from its model before it applies that edge's update, then compares every output on the next falling edge. That way each result is checked in exactly the cycle it is due.

// File: rtl/irb_pkg.sv
package irb_pkg;
  localparam int ADDR_W      = 10;
  localparam int ID_W        = 8;
  localparam int ARRAY_WORDS = 8;
  localparam int VEC_BITS    = ARRAY_WORDS * 32;

  // word addresses of each register region
  localparam logic [ADDR_W-1:0] WA_EN_SET = 10'h000;
  localparam logic [ADDR_W-1:0] WA_EN_CLR = 10'h020;
  localparam logic [ADDR_W-1:0] WA_PD_SET = 10'h040;
  localparam logic [ADDR_W-1:0] WA_PD_CLR = 10'h060;
  localparam logic [ADDR_W-1:0] WA_ACT    = 10'h080;
  localparam logic [ADDR_W-1:0] WA_PRIO   = 10'h0C0;
  localparam logic [ADDR_W-1:0] WA_TRIG   = 10'h380;
endpackage

// File: rtl/irb_id_onehot.sv
module irb_id_onehot
  import irb_pkg::*;
#(
  parameter int NUM_SRC = 60
) (
  input  logic               valid,
  input  logic [ID_W-1:0]    id,
  output logic [NUM_SRC-1:0] vec
);
  // numbers at or above NUM_SRC match no bit
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign vec[i] = valid && (id == ID_W'(i));
  end
endmodule

// File: rtl/irb_wr_decode.sv
module irb_wr_decode
  import irb_pkg::*;
#(
  parameter int NUM_SRC = 60
) (
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  input  logic [3:0]         wstrb,
  output logic [NUM_SRC-1:0] en_set,
  output logic [NUM_SRC-1:0] en_clr,
  output logic [NUM_SRC-1:0] pd_set,
  output logic [NUM_SRC-1:0] pd_clr,
  output logic [NUM_SRC-1:0] prio_we
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int WRD = n / 32;
    localparam int BIT = n % 32;
    localparam int PWD = n / 4;
    localparam int PBY = n % 4;
    logic one;
    assign one        = wr && wdata[BIT] && wstrb[BIT/8];
    assign en_set[n]  = one && (addr == WA_EN_SET + ADDR_W'(WRD));
    assign en_clr[n]  = one && (addr == WA_EN_CLR + ADDR_W'(WRD));
    assign pd_set[n]  = one && (addr == WA_PD_SET + ADDR_W'(WRD));
    assign pd_clr[n]  = one && (addr == WA_PD_CLR + ADDR_W'(WRD));
    assign prio_we[n] = wr && wstrb[PBY] && (addr == WA_PRIO + ADDR_W'(PWD));
  end
endmodule

// File: rtl/irb_setclr_bank.sv
module irb_setclr_bank #(
  parameter int NUM_SRC = 60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] sw_set,
  input  logic [NUM_SRC-1:0] sw_clr,
  input  logic [NUM_SRC-1:0] hw_set,
  input  logic [NUM_SRC-1:0] hw_clr,
  output logic [NUM_SRC-1:0] state
);
  // any set source wins over any clear source in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) state <= '0;
    else        state <= (state & ~sw_clr & ~hw_clr) | sw_set | hw_set;
  end
endmodule

// File: rtl/irb_prio_store.sv
module irb_prio_store #(
  parameter int NUM_SRC = 60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   we,
  input  logic [31:0]          wdata,
  output logic [NUM_SRC*8-1:0] prio_flat
);
  always_ff @(posedge clk) begin
    if (!rst_n) prio_flat <= '0;
    else begin
      for (int n = 0; n < NUM_SRC; n++) begin
        if (we[n]) prio_flat[n*8 +: 8] <= wdata[(n%4)*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/irb_read_mux.sv
module irb_read_mux
  import irb_pkg::*;
#(
  parameter int NUM_SRC = 60
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_SRC-1:0]   enable,
  input  logic [NUM_SRC-1:0]   pending,
  input  logic [NUM_SRC-1:0]   active,
  input  logic [NUM_SRC*8-1:0] prio_flat,
  output logic [31:0]          word
);
  localparam int PRIO_WORDS = (NUM_SRC + 3) / 4;
  localparam int PRIO_BITS  = PRIO_WORDS * 32;

  logic [VEC_BITS-1:0]  en_p, pd_p, ac_p;
  logic [PRIO_BITS-1:0] pr_p;
  assign en_p = VEC_BITS'(enable);
  assign pd_p = VEC_BITS'(pending);
  assign ac_p = VEC_BITS'(active);
  assign pr_p = PRIO_BITS'(prio_flat);

  always_comb begin
    word = '0;
    for (int w = 0; w < ARRAY_WORDS; w++) begin
      if (addr == WA_EN_SET + ADDR_W'(w) || addr == WA_EN_CLR + ADDR_W'(w))
        word = en_p[w*32 +: 32];
      if (addr == WA_PD_SET + ADDR_W'(w) || addr == WA_PD_CLR + ADDR_W'(w))
        word = pd_p[w*32 +: 32];
      if (addr == WA_ACT + ADDR_W'(w))
        word = ac_p[w*32 +: 32];
    end
    for (int w = 0; w < PRIO_WORDS; w++) begin
      if (addr == WA_PRIO + ADDR_W'(w)) word = pr_p[w*32 +: 32];
    end
  end
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irb_pkg::*;
#(
  parameter int NUM_SRC = 60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [3:0]           bus_wstrb,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NUM_SRC-1:0]   irq_req,
  input  logic                 ack_valid,
  input  logic [ID_W-1:0]      ack_id,
  input  logic                 done_valid,
  input  logic [ID_W-1:0]      done_id,
  output logic [NUM_SRC-1:0]   enable_o,
  output logic [NUM_SRC-1:0]   pending_o,
  output logic [NUM_SRC-1:0]   active_o,
  output logic [NUM_SRC*8-1:0] prio_o
);
  logic [NUM_SRC-1:0] en_set, en_clr, pd_set, pd_clr, prio_we;
  logic [NUM_SRC-1:0] trig_vec, ack_vec, done_vec, pd_sw_set;
  logic [31:0]        rd_word;
  logic               trig_hit;

  irb_wr_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .wstrb(bus_wstrb),
    .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
    .prio_we(prio_we)
  );

  assign trig_hit = bus_wr && bus_wstrb[0] && (bus_addr == WA_TRIG);

  irb_id_onehot #(.NUM_SRC(NUM_SRC)) u_trig (
    .valid(trig_hit), .id(bus_wdata[ID_W-1:0]), .vec(trig_vec));
  irb_id_onehot #(.NUM_SRC(NUM_SRC)) u_ack (
    .valid(ack_valid), .id(ack_id), .vec(ack_vec));
  irb_id_onehot #(.NUM_SRC(NUM_SRC)) u_done (
    .valid(done_valid), .id(done_id), .vec(done_vec));

  assign pd_sw_set = pd_set | trig_vec;

  irb_setclr_bank #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk(clk), .rst_n(rst_n), .sw_set(en_set), .sw_clr(en_clr),
    .hw_set('0), .hw_clr('0), .state(enable_o));

  // request beats both software clear and acknowledge
  irb_setclr_bank #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk(clk), .rst_n(rst_n), .sw_set(pd_sw_set), .sw_clr(pd_clr),
    .hw_set(irq_req), .hw_clr(ack_vec), .state(pending_o));

  // hardware-only: acknowledge raises, completion drops
  irb_setclr_bank #(.NUM_SRC(NUM_SRC)) u_active (
    .clk(clk), .rst_n(rst_n), .sw_set('0), .sw_clr('0),
    .hw_set(ack_vec), .hw_clr(done_vec), .state(active_o));

  irb_prio_store #(.NUM_SRC(NUM_SRC)) u_prio (
    .clk(clk), .rst_n(rst_n), .we(prio_we), .wdata(bus_wdata),
    .prio_flat(prio_o));

  irb_read_mux #(.NUM_SRC(NUM_SRC)) u_rmux (
    .addr(bus_addr), .enable(enable_o), .pending(pending_o),
    .active(active_o), .prio_flat(prio_o), .word(rd_word));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/irb_checker.sv
module irb_checker
  import irb_pkg::*;
#(
  parameter int NUM_SRC = 60
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic               bus_rvalid,
  input logic [NUM_SRC-1:0] irq_req,
  input logic               ack_valid,
  input logic [ID_W-1:0]    ack_id,
  input logic [NUM_SRC-1:0] enable_o,
  input logic [NUM_SRC-1:0] pending_o,
  input logic [NUM_SRC-1:0] active_o
);
  logic [NUM_SRC-1:0] ack_vec;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
    assign ack_vec[i] = ack_valid && (ack_id == ID_W'(i));
  end

  assert_rd_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_no_spurious_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  assert_req_sets_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != '0) |=> ((pending_o & $past(irq_req)) == $past(irq_req)));

  assert_ack_sets_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0) |=> ((active_o & $past(ack_vec)) == $past(ack_vec)));

  assert_ack_clears_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && ((ack_vec & ~irq_req) != '0))
      |=> ((pending_o & $past(ack_vec & ~irq_req)) == '0));

  assert_active_hw_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> ((active_o & ~$past(active_o) & ~$past(ack_vec)) == '0));

  assert_enable_needs_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(enable_o));
endmodule

bind irq_state_bank irb_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rvalid(bus_rvalid), .irq_req(irq_req), .ack_valid(ack_valid),
  .ack_id(ack_id), .enable_o(enable_o), .pending_o(pending_o),
  .active_o(active_o)
);

// File: tb/sim_irq_state_bank.sv
`timescale 1ns/1ps
module sim_irq_state_bank;
  localparam int NUM = 60;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [3:0]      bus_wstrb = '0;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic [NUM-1:0]  irq_req = '0;
  logic            ack_valid = 1'b0, done_valid = 1'b0;
  logic [7:0]      ack_id = '0, done_id = '0;
  logic [NUM-1:0]  enable_o, pending_o, active_o;
  logic [NUM*8-1:0] prio_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [NUM-1:0] m_en = '0, m_pd = '0, m_ac = '0;
  logic [7:0]     m_pr [NUM];

  always #4 clk = ~clk;  // 125 MHz

  irq_state_bank #(.NUM_SRC(NUM)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_req(irq_req),
    .ack_valid(ack_valid), .ack_id(ack_id), .done_valid(done_valid),
    .done_id(done_id), .enable_o(enable_o), .pending_o(pending_o),
    .active_o(active_o), .prio_o(prio_o));

  task automatic chk(string tag, string what, logic [NUM*8-1:0] act, logic [NUM*8-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] vec_word(logic [NUM-1:0] v, int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      if (w*32 + b < NUM) r[b] = v[w*32 + b];
    end
    return r;
  endfunction

  // expected read word per R3, R8, R9
  function automatic logic [31:0] exp_read(logic [9:0] a);
    int ai = int'(a);
    logic [31:0] r = '0;
    if (ai < 8)                    r = vec_word(m_en, ai);
    else if (ai >= 32 && ai < 40)  r = vec_word(m_en, ai - 32);
    else if (ai >= 64 && ai < 72)  r = vec_word(m_pd, ai - 64);
    else if (ai >= 96 && ai < 104) r = vec_word(m_pd, ai - 96);
    else if (ai >= 128 && ai < 136) r = vec_word(m_ac, ai - 128);
    else if (ai >= 192 && ai < 256) begin
      for (int k = 0; k < 4; k++) begin
        if ((ai - 192)*4 + k < NUM) r[k*8 +: 8] = m_pr[(ai - 192)*4 + k];
      end
    end
    return r;
  endfunction

  function automatic logic [NUM*8-1:0] prio_flat();
    logic [NUM*8-1:0] f;
    for (int n = 0; n < NUM; n++) f[n*8 +: 8] = m_pr[n];
    return f;
  endfunction

  // model update for one edge, from the inputs held at that edge
  task automatic model_step();
    logic [NUM-1:0] n_en, n_pd, n_ac;
    int ai;
    n_en = m_en; n_pd = m_pd; n_ac = m_ac;
    ai = int'(bus_addr);
    for (int n = 0; n < NUM; n++) begin
      int w = n / 32;
      int b = n % 32;
      bit ok = bus_wr && bus_wdata[b] && bus_wstrb[b/8];
      bit sset = ok && ai == 64 + w;
      bit sclr = ok && ai == 96 + w;
      bit trg = bus_wr && bus_wstrb[0] && ai == 896 && int'(bus_wdata[7:0]) == n;
      bit am = ack_valid && int'(ack_id) == n;
      bit dm = done_valid && int'(done_id) == n;
      if (ok && ai == w)      n_en[n] = 1'b1;
      if (ok && ai == 32 + w) n_en[n] = 1'b0;
      if (irq_req[n] || sset || trg) n_pd[n] = 1'b1;
      else if (sclr || am)           n_pd[n] = 1'b0;
      if (am)      n_ac[n] = 1'b1;
      else if (dm) n_ac[n] = 1'b0;
      if (bus_wr && ai == 192 + n/4 && bus_wstrb[n%4])
        m_pr[n] = bus_wdata[(n%4)*8 +: 8];
    end
    m_en = n_en; m_pd = n_pd; m_ac = n_ac;
  endtask

  function automatic string pick(string tag, string dflt);
    return (tag == "") ? dflt : tag;
  endfunction

  // one bus/hardware cycle, called on a falling edge
  task automatic cyc(logic wr, logic rd, logic [9:0] a, logic [31:0] d, logic [3:0] s,
                     logic [NUM-1:0] rq, logic av, logic [7:0] aid,
                     logic dv, logic [7:0] did, string tag);
    logic [31:0] er;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    irq_req = rq; ack_valid = av; ack_id = aid; done_valid = dv; done_id = did;
    er = exp_read(a);
    @(posedge clk);
    model_step();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; irq_req = '0; ack_valid = 0; done_valid = 0;
    chk(pick(tag, "R1"), "enable", (NUM*8)'(enable_o), (NUM*8)'(m_en));
    chk(pick(tag, "R4"), "pending", (NUM*8)'(pending_o), (NUM*8)'(m_pd));
    chk(pick(tag, "R6"), "active", (NUM*8)'(active_o), (NUM*8)'(m_ac));
    chk(pick(tag, "R8"), "priority", prio_o, prio_flat());
    chk("R11", "rvalid", (NUM*8)'(bus_rvalid), (NUM*8)'(rd));
    if (rd) chk(pick(tag, "R3"), "rdata", (NUM*8)'(bus_rdata), (NUM*8)'(er));
  endtask

  task automatic wr_op(logic [9:0] a, logic [31:0] d, logic [3:0] s, string tag);
    cyc(1, 0, a, d, s, '0, 0, 0, 0, 0, tag);
  endtask

  task automatic rd_op(logic [9:0] a, string tag);
    cyc(0, 1, a, 0, 0, '0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < NUM; n++) m_pr[n] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state (R11)
    chk("R11", "reset enable", (NUM*8)'(enable_o), '0);
    chk("R11", "reset pending", (NUM*8)'(pending_o), '0);
    chk("R11", "reset active", (NUM*8)'(active_o), '0);
    chk("R11", "reset priority", prio_o, '0);
    rd_op(10'h000, "R11");

    // R1: set alias, zeros ignored
    wr_op(10'h000, 32'h0000_00F0, 4'b0001, "R1");
    wr_op(10'h000, 32'h0000_0000, 4'b1111, "R1");
    rd_op(10'h020, "R3");
    rd_op(10'h000, "R3");
    // R2: clear alias
    wr_op(10'h020, 32'h0000_0010, 4'b1111, "R2");
    rd_op(10'h000, "R2");
    // R12: strobes gate set bits
    wr_op(10'h000, 32'hFFFF_FFFF, 4'b0100, "R12");
    wr_op(10'h020, 32'hFFFF_FFFF, 4'b1000, "R12");
    // R9: word 1 upper bits and word 2 absent
    wr_op(10'h001, 32'hFFFF_FFFF, 4'b1111, "R9");
    rd_op(10'h001, "R9");
    wr_op(10'h002, 32'hFFFF_FFFF, 4'b1111, "R9");
    rd_op(10'h002, "R9");
    // R4: pending aliases
    wr_op(10'h040, 32'h0000_0009, 4'b0001, "R4");
    wr_op(10'h060, 32'h0000_0001, 4'b0001, "R4");
    rd_op(10'h060, "R4");
    // R5: request and software clear in the same cycle
    cyc(1, 0, 10'h060, 32'h0000_0008, 4'b0001, NUM'(1) << 3, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, NUM'(1) << 40, 0, 0, 0, 0, "R5");
    // R6: acknowledge, then completion; ack with simultaneous request
    cyc(0, 0, 0, 0, 0, '0, 1, 8'd3, 0, 0, "R6");
    rd_op(10'h080, "R6");
    cyc(0, 0, 0, 0, 0, NUM'(1) << 40, 1, 8'd40, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, '0, 1, 8'd40, 1, 8'd40, "R6");
    cyc(0, 0, 0, 0, 0, '0, 0, 0, 1, 8'd3, "R6");
    cyc(0, 0, 0, 0, 0, '0, 1, 8'd62, 1, 8'd61, "R9");
    // R7: active is read-only
    wr_op(10'h080, 32'hFFFF_FFFF, 4'b1111, "R7");
    wr_op(10'h081, 32'hFFFF_FFFF, 4'b1111, "R7");
    rd_op(10'h081, "R7");
    // R10: trigger in and out of range
    wr_op(10'h380, 32'h0000_002D, 4'b0001, "R10");
    wr_op(10'h380, 32'h0000_0046, 4'b0001, "R10");
    wr_op(10'h380, 32'h0000_0011, 4'b0010, "R10");
    rd_op(10'h041, "R10");
    // R8: priority bytes with strobes
    wr_op(10'h0C2, 32'hAABB_CCDD, 4'b0101, "R8");
    rd_op(10'h0C2, "R8");
    wr_op(10'h0CE, 32'h1122_3344, 4'b1111, "R8");
    rd_op(10'h0CE, "R8");
    wr_op(10'h0CF, 32'h5566_7788, 4'b1111, "R9");
    rd_op(10'h0CF, "R9");
    rd_op(10'h3FF, "R3");

    // constrained random mix
    for (int it = 0; it < 1500; it++) begin
      logic [9:0]     a;
      logic [31:0]    d;
      logic [3:0]     s;
      logic [NUM-1:0] rq;
      logic           wr, rd, av, dv;
      int             op;
      op = int'($urandom % 8);
      wr = (op != 7);
      rd = (op == 7);
      d  = $urandom;
      s  = 4'($urandom);
      case (op)
        0: a = 10'(32'h000 + $urandom % 3);
        1: a = 10'(32'h020 + $urandom % 3);
        2: a = 10'(32'h040 + $urandom % 3);
        3: a = 10'(32'h060 + $urandom % 3);
        4: begin a = 10'h380; d = $urandom % 80; end
        5: a = 10'(32'h0C0 + $urandom % 17);
        6: a = 10'(32'h080 + $urandom % 2);
        default: begin
          logic [9:0] bases [6] = '{10'h000, 10'h020, 10'h040, 10'h060, 10'h080, 10'h0C0};
          a = bases[$urandom % 6] + 10'($urandom % 16);
        end
      endcase
      rq = ($urandom % 4 == 0) ? (NUM'({$urandom, $urandom}) & NUM'({$urandom, $urandom}) &
                                  NUM'({$urandom, $urandom})) : '0;
      av = ($urandom % 3 == 0);
      dv = ($urandom % 3 == 0);
      cyc(wr, rd, a, d, s, rq, av, 8'($urandom % 64), dv, 8'($urandom % 64), "");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule